// File: doc/BRIEF.md
# Privileged System Instruction Classifier

This decode-stage unit looks at one 32-bit instruction word together with its program counter and the two aligned 32-bit words on either side of it. It sorts the privileged system instructions into outcomes. An instruction can raise a trap with a cause code, be flagged illegal, request a return from trap, request a wait for interrupt, or pulse a flush of the whole address-translation cache. The unit also puts out the address of the sequential successor instruction.

Its most involved job concerns the breakpoint instruction. A breakpoint becomes a semihosting request only when it sits between two fixed marker words. All three words must be full-length encodings, and the two outer words must lie in the same page. In every other case the breakpoint stays an ordinary debug breakpoint.

All outputs are registered. A decision appears one clock after `dec_valid` is sampled high. The pulse-type outputs drop again in the first cycle after a cycle without a valid instruction.

Top module: `priv_sys_classifier`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, every output is zero, including `next_pc`.
- R2: The environment call (word 0x00000073) raises `trap_req` with cause 8 and `redirect`, whatever the privilege setting. This happens one clock after the word is sampled with `dec_valid` high.
- R3: The breakpoint (word 0x00100073) raises cause 24 when three conditions hold. The previous word must be 0x01f01013, the following word must be 0x40705013, and both neighbour valid flags must be high. In addition, PC-4 and PC+4 must have equal bits [31:12].
- R4: If PC-4 and PC+4 fall in different 4 KiB pages, the breakpoint raises cause 3 even when the marker words are present.
- R5: A neighbour valid flag that is low, a neighbour word that differs from its marker, or a neighbour whose bits [1:0] are not 2'b11 makes the breakpoint raise cause 3. Every breakpoint also asserts `redirect`.
- R6: The supervisor return (word 0x10200073) asserts `ret_req`, `ret_to_sup` and `redirect` with no trap when `sup_en` is high. When `sup_en` is low it raises `illegal` and a trap with cause 2.
- R7: The machine return (word 0x30200073) asserts `ret_req` and `redirect` with `ret_to_sup` low and no trap, regardless of `sup_en`.
- R8: The user return (word 0x00200073) and the legacy fence (word & 0xFFF07FFF equal to 0x10400073) always raise `illegal`, `trap_req` with cause 2, and `redirect`.
- R9: Wait-for-interrupt (word 0x10500073) asserts `wfi_req` with no trap and no redirect. `next_pc` then equals its PC+4.
- R10: The address-translation fence (word & 0xFE007FFF equal to 0x12000073, any rs1/rs2) asserts `tlb_flush` with no trap and no redirect. `tlb_flush` falls in the cycle after one without `dec_valid`.
- R11: Any other word, or a cycle with `dec_valid` low, leaves every request output low. `next_pc` takes PC+4 of each valid word and holds its value while `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Instruction word present this cycle |
| dec_instr | input | 32 | Instruction word under decode |
| dec_pc | input | 32 | Address of the instruction word |
| prev_word | input | 32 | Word at PC-4 |
| prev_ok | input | 1 | Word at PC-4 is valid |
| next_word | input | 32 | Word at PC+4 |
| next_ok | input | 1 | Word at PC+4 is valid |
| sup_en | input | 1 | Supervisor extension enabled |
| trap_req | output | 1 | Trap request |
| trap_cause | output | 6 | Trap cause code |
| illegal | output | 1 | Illegal-instruction flag |
| redirect | output | 1 | Flow ends; PC comes from trap or return logic |
| ret_req | output | 1 | Return-from-trap request |
| ret_to_sup | output | 1 | Return is the supervisor form |
| next_pc | output | 32 | Sequential successor address (PC+4) |
| tlb_flush | output | 1 | Flush the whole translation cache |
| wfi_req | output | 1 | Wait-for-interrupt request |

## Verification
The bench aims at the page boundary from both sides: a breakpoint at an offset of 0xFF8 stays inside one page, while offsets 0xFFC and 0x000 straddle a boundary. A design that compared the wrong address bits, or used PC instead of the outer words, would report semihosting in the straddling cases or lose it at 0xFF8. It also clears each neighbour valid flag in turn and perturbs the low two bits of a marker. A design that ignored either would wrongly promote a plain breakpoint. The supervisor return is checked with the enable both on and off, and the fences are checked with non-zero register fields. A mask that was too strict would miss them, and a flush that stayed high would show up once `dec_valid` drops.

// File: rtl/priv_sys_classifier.sv
module priv_sys_classifier #(
  parameter int          PAGE_BITS   = 12,
  parameter int          CAUSE_W     = 6,
  parameter logic [5:0]  SEMI_CAUSE  = 6'd24,
  parameter logic [5:0]  BRK_CAUSE   = 6'd3,
  parameter logic [5:0]  ECALL_CAUSE = 6'd8,
  parameter logic [5:0]  ILL_CAUSE   = 6'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dec_valid,
  input  logic [31:0]        dec_instr,
  input  logic [31:0]        dec_pc,
  input  logic [31:0]        prev_word,
  input  logic               prev_ok,
  input  logic [31:0]        next_word,
  input  logic               next_ok,
  input  logic               sup_en,
  output logic               trap_req,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic               illegal,
  output logic               redirect,
  output logic               ret_req,
  output logic               ret_to_sup,
  output logic [31:0]        next_pc,
  output logic               tlb_flush,
  output logic               wfi_req
);

  localparam logic [31:0] MARK_LO  = 32'h01f01013;
  localparam logic [31:0] MARK_HI  = 32'h40705013;
  localparam logic [31:0] W_ECALL  = 32'h00000073;
  localparam logic [31:0] W_EBREAK = 32'h00100073;
  localparam logic [31:0] W_URET   = 32'h00200073;
  localparam logic [31:0] W_SRET   = 32'h10200073;
  localparam logic [31:0] W_MRET   = 32'h30200073;
  localparam logic [31:0] W_WFI    = 32'h10500073;
  localparam logic [31:0] M_FVM    = 32'hFFF07FFF;
  localparam logic [31:0] W_FVM    = 32'h10400073;
  localparam logic [31:0] M_FVMA   = 32'hFE007FFF;
  localparam logic [31:0] W_FVMA   = 32'h12000073;
  localparam int          PG_W     = 32 - PAGE_BITS;

  logic [31:0] pc_lo, pc_hi;
  logic        same_page, semi_hit;
  logic        is_ecall, is_ebreak, is_uret, is_sret, is_mret;
  logic        is_wfi, is_fvm, is_fvma, bad;

  assign pc_lo     = dec_pc - 32'd4;
  assign pc_hi     = dec_pc + 32'd4;
  assign same_page = pc_lo[31 -: PG_W] == pc_hi[31 -: PG_W];

  assign is_ecall  = dec_instr == W_ECALL;
  assign is_ebreak = dec_instr == W_EBREAK;
  assign is_uret   = dec_instr == W_URET;
  assign is_sret   = dec_instr == W_SRET;
  assign is_mret   = dec_instr == W_MRET;
  assign is_wfi    = dec_instr == W_WFI;
  assign is_fvm    = (dec_instr & M_FVM) == W_FVM;
  assign is_fvma   = (dec_instr & M_FVMA) == W_FVMA;
  assign bad       = is_uret | is_fvm | (is_sret & ~sup_en);

  assign semi_hit = same_page & prev_ok & next_ok &
                    (prev_word[1:0] == 2'b11) & (next_word[1:0] == 2'b11) &
                    (prev_word == MARK_LO) & (next_word == MARK_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req   <= 1'b0;
      trap_cause <= '0;
      illegal    <= 1'b0;
      redirect   <= 1'b0;
      ret_req    <= 1'b0;
      ret_to_sup <= 1'b0;
      next_pc    <= '0;
      tlb_flush  <= 1'b0;
      wfi_req    <= 1'b0;
    end else begin
      trap_req   <= dec_valid & (is_ecall | is_ebreak | bad);
      illegal    <= dec_valid & bad;
      redirect   <= dec_valid & (is_ecall | is_ebreak | bad | is_mret | (is_sret & sup_en));
      ret_req    <= dec_valid & (is_mret | (is_sret & sup_en));
      ret_to_sup <= dec_valid & is_sret & sup_en;
      tlb_flush  <= dec_valid & is_fvma;
      wfi_req    <= dec_valid & is_wfi;
      if (!dec_valid)     trap_cause <= '0;
      else if (bad)       trap_cause <= ILL_CAUSE[CAUSE_W-1:0];
      else if (is_ecall)  trap_cause <= ECALL_CAUSE[CAUSE_W-1:0];
      else if (is_ebreak) trap_cause <= semi_hit ? SEMI_CAUSE[CAUSE_W-1:0] : BRK_CAUSE[CAUSE_W-1:0];
      else                trap_cause <= '0;
      if (dec_valid) next_pc <= pc_hi;
    end
  end

  // R8
  ill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (trap_req && trap_cause == ILL_CAUSE[CAUSE_W-1:0] && redirect));

  // R9
  wfi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wfi_req |-> (!trap_req && !redirect && !ret_req));

  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> (!trap_req && !redirect));

  // R3
  semi_needs_nbrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_cause == SEMI_CAUSE[CAUSE_W-1:0]) |-> $past(dec_valid && prev_ok && next_ok));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dec_valid) |-> ($stable(next_pc) && !trap_req && !tlb_flush && !wfi_req && !ret_req));

  // R6
  ret_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_req, ret_req, wfi_req, tlb_flush}));

endmodule

// File: tb/priv_sys_classifier_tb.sv
module priv_sys_classifier_tb_top;

  typedef struct packed {
    logic [31:0] ins, pc, pw, nw;
    logic        pv, nv, sup;
    logic        trap;
    logic [5:0]  cause;
    logic        ill, rdr, ret, rsup, wfi, fl;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] LO = 32'h01f01013;
  localparam logic [31:0] HI = 32'h40705013;
  localparam logic [31:0] EB = 32'h00100073;
  localparam int NV = 16;

  localparam vec_t VECS [NV] = '{
    '{32'h00000073, 32'h2008, LO, HI, 1'b1, 1'b1, 1'b0, 1'b1, 6'd8,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{EB,           32'h2008, LO, HI, 1'b1, 1'b1, 1'b0, 1'b1, 6'd24, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
    '{EB,           32'h2FF8, LO, HI, 1'b1, 1'b1, 1'b0, 1'b1, 6'd24, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
    '{EB,           32'h2FFC, LO, HI, 1'b1, 1'b1, 1'b0, 1'b1, 6'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{EB,           32'h3000, LO, HI, 1'b1, 1'b1, 1'b0, 1'b1, 6'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{EB,           32'h2008, LO, HI, 1'b0, 1'b1, 1'b0, 1'b1, 6'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{EB,           32'h2008, LO, HI, 1'b1, 1'b0, 1'b0, 1'b1, 6'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{EB,           32'h2008, LO, 32'h40705012, 1'b1, 1'b1, 1'b0, 1'b1, 6'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
    '{EB,           32'h2008, 32'h00000013, HI, 1'b1, 1'b1, 1'b0, 1'b1, 6'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
    '{32'h10200073, 32'h4000, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
    '{32'h10200073, 32'h4000, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{32'h30200073, 32'h4010, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{32'h00200073, 32'h4020, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{32'h10450073, 32'h4030, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{32'h10500073, 32'h5FFC, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd9},  // R9
    '{32'h12B50073, 32'h6000, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10}  // R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0, prev_ok = 1'b0, next_ok = 1'b0, sup_en = 1'b0;
  logic [31:0] dec_instr = '0, dec_pc = '0, prev_word = '0, next_word = '0;
  logic trap_req, illegal, redirect, ret_req, ret_to_sup, tlb_flush, wfi_req;
  logic [5:0] trap_cause;
  logic [31:0] next_pc;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  priv_sys_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_instr(dec_instr),
    .dec_pc(dec_pc), .prev_word(prev_word), .prev_ok(prev_ok),
    .next_word(next_word), .next_ok(next_ok), .sup_en(sup_en),
    .trap_req(trap_req), .trap_cause(trap_cause), .illegal(illegal),
    .redirect(redirect), .ret_req(ret_req), .ret_to_sup(ret_to_sup),
    .next_pc(next_pc), .tlb_flush(tlb_flush), .wfi_req(wfi_req)
  );

  function automatic logic [45:0] outs();
    return {trap_req, trap_cause, illegal, redirect, ret_req, ret_to_sup, wfi_req, tlb_flush, next_pc};
  endfunction

  task automatic check(input string req, input logic [45:0] act, input logic [45:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    check("R1", outs(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", outs(), '0);

    for (int i = 0; i < NV; i++) begin
      dec_valid = 1'b1;
      dec_instr = VECS[i].ins; dec_pc = VECS[i].pc;
      prev_word = VECS[i].pw;  next_word = VECS[i].nw;
      prev_ok = VECS[i].pv;    next_ok = VECS[i].nv; sup_en = VECS[i].sup;
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), outs(),
            {VECS[i].trap, VECS[i].cause, VECS[i].ill, VECS[i].rdr, VECS[i].ret,
             VECS[i].rsup, VECS[i].wfi, VECS[i].fl, VECS[i].pc + 32'd4});
    end

    // R10: flush drops once dec_valid falls; R11: next_pc held
    dec_valid = 1'b0;
    @(negedge clk);
    check("R10 flush clears", outs(), {14'b0, 32'h6004});

    // R11: ECALL word with dec_valid low has no effect
    dec_instr = 32'h00000073; dec_pc = 32'h7000;
    @(negedge clk);
    check("R11 idle ecall", outs(), {14'b0, 32'h6004});

    // R11: ordinary instruction
    dec_valid = 1'b1; dec_instr = 32'h00100093; dec_pc = 32'h7100;
    @(negedge clk);
    check("R11 addi", outs(), {14'b0, 32'h7104});

    // R2: ECALL with supervisor enable still cause 8
    dec_instr = 32'h00000073; dec_pc = 32'h7200; sup_en = 1'b1;
    @(negedge clk);
    check("R2 sup", outs(), {1'b1, 6'd8, 1'b0, 1'b1, 4'b0, 32'h7204});

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 rerun", outs(), '0);
    dec_valid = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    check("R1 after", outs(), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule